// File: doc/BRIEF.md
# Interleaved Chroma DC Reconstruction Unit

This unit rebuilds one chroma plane of a 4x4 block when the two chroma planes share a buffer with their bytes alternating. The residual of the block is a single DC term that arrives already dequantized. A start pulse captures that value and turns it into a residual by a rounding right shift of six. The block then accepts four rows. Each row beat carries eight interleaved prediction bytes and the eight bytes that the destination row currently holds.

For every row, the samples at the even byte positions are taken from the prediction. The residual is added to each of them and the result is saturated to the 8-bit range. The results are written back into the even positions of the destination row. The odd positions belong to the other plane, and they are copied from the incoming destination bytes without change. The merged row leaves on a valid/ready output. A one-cycle done pulse marks the hand-off of the fourth row.

Top module: `chroma_dc_merge`

## Requirements
- R1: On a start pulse while idle, the residual is captured as floor((dc + 32) / 64), where dc is the signed 16-bit input. All four rows of that block use this residual.
- R2: Byte k of a row occupies bits [8k+7:8k]. For k in {0, 2, 4, 6}, output byte k equals prediction byte k plus the residual, saturated to 0..255.
- R3: For k in {1, 3, 5, 7}, output byte k equals byte k of the incoming destination row of the same beat.
- R4: A sum below zero, including one produced by a negative DC, gives 0.
- R5: A sum above 255 gives 255.
- R6: While idle, row_ready is low, and a row_valid does not produce any output. After a start, exactly four rows are accepted.
- R7: While out_valid is high and out_ready is low, out_valid stays high, out_row holds its value, and row_ready is low.
- R8: done is high for exactly one cycle. That cycle follows the cycle in which the fourth merged row is taken. After it the unit is idle.
- R9: A start pulse while a block is in progress is ignored, and the remaining rows keep the original residual.
- R10: After reset, out_valid, done and row_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a block and capture dc_in |
| dc_in | input | 16 | Signed DC value, already dequantized |
| row_valid | input | 1 | An input row beat is offered |
| row_ready | output | 1 | The unit takes the input row beat |
| pred_row | input | 64 | Interleaved prediction bytes, byte k at [8k+7:8k] |
| cur_row | input | 64 | Current destination row bytes |
| out_valid | output | 1 | A merged row is held |
| out_ready | input | 1 | The consumer takes the merged row |
| out_row | output | 64 | Merged destination row |
| done | output | 1 | One-cycle pulse after the fourth row is taken |

## Verification
A wrong captured residual offsets every even byte of the next output row by a constant. This shows on the first merged row, one cycle after that row is accepted. A row counter that is off by one shows as a missing or early done pulse, or as a fifth row being accepted, at the end of the block. A fault in the output register shows at once under backpressure: the held row changes, or a new row is accepted while out_valid is still high. The table of DC values checks the rounding for negative values exactly at the half-step boundaries, such as -33 and -32. It also checks both saturation rails.

// File: rtl/chroma_dc_merge_pkg.sv
package chroma_dc_merge_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } cdm_state_e;

    localparam int CDM_PIX_W  = 8;
    localparam int CDM_LANES  = 4;
    localparam int CDM_ROWS   = 4;
    localparam int CDM_DC_W   = 16;
    localparam int CDM_SHIFT  = 6;
endpackage

// File: rtl/cdm_dc_round.sv
module cdm_dc_round #(
    parameter int DC_W  = 16,
    parameter int SHIFT = 6,
    localparam int RES_W = DC_W + 1 - SHIFT
) (
    input  logic signed [DC_W-1:0]  dc,
    output logic signed [RES_W-1:0] res
);
    localparam int HALF = 1 << (SHIFT - 1);

    logic signed [DC_W:0] ext;
    logic signed [DC_W:0] biased;

    always_comb begin
        ext    = {dc[DC_W-1], dc};
        biased = ext + (DC_W+1)'(HALF);
        res    = RES_W'(biased >>> SHIFT);
    end
endmodule

// File: rtl/cdm_lane_sat.sv
module cdm_lane_sat #(
    parameter int PIX_W = 8,
    parameter int RES_W = 11
) (
    input  logic [PIX_W-1:0]        pred,
    input  logic signed [RES_W-1:0] res,
    output logic [PIX_W-1:0]        pix
);
    localparam int SUM_W = RES_W + 1;
    localparam int PMAX  = (1 << PIX_W) - 1;

    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum = $signed({{(SUM_W-PIX_W){1'b0}}, pred}) + $signed({res[RES_W-1], res});
        if (sum[SUM_W-1]) begin
            pix = '0;
        end else if (sum > $signed(SUM_W'(PMAX))) begin
            pix = '1;
        end else begin
            pix = sum[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/chroma_dc_merge.sv
module chroma_dc_merge
    import chroma_dc_merge_pkg::*;
#(
    parameter int PIX_W = CDM_PIX_W,
    parameter int LANES = CDM_LANES,
    parameter int ROWS  = CDM_ROWS,
    parameter int DC_W  = CDM_DC_W,
    parameter int SHIFT = CDM_SHIFT,
    localparam int ROW_W = 2 * LANES * PIX_W,
    localparam int RES_W = DC_W + 1 - SHIFT,
    localparam int CNT_W = $clog2(ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DC_W-1:0]  dc_in,
    input  logic             row_valid,
    output logic             row_ready,
    input  logic [ROW_W-1:0] pred_row,
    input  logic [ROW_W-1:0] cur_row,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [ROW_W-1:0] out_row,
    output logic             done
);
    typedef struct packed {
        cdm_state_e              st;
        logic signed [RES_W-1:0] res;
        logic [CNT_W-1:0]        in_cnt;
        logic [CNT_W-1:0]        out_cnt;
        logic                    ov;
        logic [ROW_W-1:0]        orow;
        logic                    done;
    } regs_t;

    regs_t q, d;

    logic signed [RES_W-1:0] res_new;
    logic [ROW_W-1:0]        merged;
    logic [ROW_W/2-1:0]      unused_bits;
    logic                    in_fire;
    logic                    out_fire;

    cdm_dc_round #(.DC_W(DC_W), .SHIFT(SHIFT)) u_round (
        .dc  ($signed(dc_in)),
        .res (res_new)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int EV = 2 * i * PIX_W;
        localparam int OD = EV + PIX_W;

        cdm_lane_sat #(.PIX_W(PIX_W), .RES_W(RES_W)) u_sat (
            .pred (pred_row[EV +: PIX_W]),
            .res  (q.res),
            .pix  (merged[EV +: PIX_W])
        );
        assign merged[OD +: PIX_W] = cur_row[OD +: PIX_W];
        assign unused_bits[i*PIX_W +: PIX_W] = pred_row[OD +: PIX_W] ^ cur_row[EV +: PIX_W];

        a_r3_odd_kept: assert property (@(posedge clk) disable iff (!rst_n)
            in_fire |=> out_row[OD +: PIX_W] == $past(cur_row[OD +: PIX_W]));
    end

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        row_ready = (q.st == ST_RUN) && (q.in_cnt != CNT_W'(ROWS)) && (!q.ov || out_ready);
        in_fire   = row_valid && row_ready;
        out_fire  = q.ov && out_ready;

        if (q.st == ST_IDLE) begin
            if (start) begin
                d.res     = res_new;
                d.in_cnt  = '0;
                d.out_cnt = '0;
                d.st      = ST_RUN;
            end
        end else begin
            if (out_fire) begin
                d.ov      = 1'b0;
                d.out_cnt = q.out_cnt + 1'b1;
                if (q.out_cnt == CNT_W'(ROWS - 1)) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            if (in_fire) begin
                d.ov     = 1'b1;
                d.orow   = merged;
                d.in_cnt = q.in_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, res: '0, in_cnt: '0, out_cnt: '0, ov: 1'b0, orow: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.ov;
    assign out_row   = q.orow;
    assign done      = q.done;

    a_r6_idle_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !row_ready);

    a_r7_hold_row: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_row));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !out_valid);

    a_r9_res_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && start) |=> $stable(q.res));
endmodule

// File: tb/chroma_dc_merge_bench.sv
module chroma_dc_merge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] dc_in = '0;
    logic        row_valid = 1'b0;
    logic        row_ready;
    logic [63:0] pred_row = '0;
    logic [63:0] cur_row = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_row;
    logic        done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    chroma_dc_merge u_chroma_dc_merge (
        .clk(clk), .rst_n(rst_n), .start(start), .dc_in(dc_in),
        .row_valid(row_valid), .row_ready(row_ready),
        .pred_row(pred_row), .cur_row(cur_row),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_row(out_row), .done(done)
    );

    localparam int NV = 8;
    localparam logic [15:0] DC_TAB [NV] = '{16'd0, 16'd100, 16'hFFDF, 16'hFFE0,
                                            16'd2000, 16'hEC78, 16'h7FFF, 16'h8000};
    localparam logic [63:0] PRED_TAB [NV] = '{64'h00FF_7F80_0102_FEFD, 64'h1122_3344_5566_77FE,
                                              64'h0000_0001_00FF_0000, 64'h8081_8283_0001_FFFE,
                                              64'hE0F0_E100_E2FF_E3A0, 64'h4D4E_4C4F_4E00_4DFF,
                                              64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF};
    localparam logic [63:0] CUR_TAB [NV] = '{64'hA5A5_5A5A_C3C3_3C3C, 64'h0123_4567_89AB_CDEF,
                                             64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000,
                                             64'h1357_9BDF_2468_ACE0, 64'hDEAD_BEEF_CAFE_F00D,
                                             64'h7777_8888_9999_AAAA, 64'h0F1E_2D3C_4B5A_6978};

    function automatic int ref_res(input logic [15:0] dc);
        int t;
        t = int'($signed(dc)) + 32;
        if (t >= 0) return t / 64;
        return -((-t + 63) / 64);
    endfunction

    function automatic logic [7:0] ref_sat(input int v);
        if (v < 0) return 8'd0;
        if (v > 255) return 8'd255;
        return 8'(v);
    endfunction

    function automatic logic [63:0] ref_row(input logic [63:0] p, input logic [63:0] c, input int r);
        logic [63:0] o;
        for (int k = 0; k < 8; k++) begin
            if (k % 2 == 0) o[8*k +: 8] = ref_sat(int'(p[8*k +: 8]) + r);
            else            o[8*k +: 8] = c[8*k +: 8];
        end
        return o;
    endfunction

    function automatic logic [63:0] rot(input logic [63:0] v, input int r);
        return (v << (8*r)) | (v >> (64 - 8*r));
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic begin_block(input logic [15:0] dc);
        @(negedge clk);
        start = 1'b1;
        dc_in = dc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_row(input logic [63:0] p, input logic [63:0] c, input int r, input string req);
        row_valid = 1'b1;
        pred_row  = p;
        cur_row   = c;
        check("R6 ready in run", 64'(row_ready), 64'd1);
        @(negedge clk);
        row_valid = 1'b0;
        check("R2/R3 out_valid", 64'(out_valid), 64'd1);
        check(req, out_row, ref_row(p, c, r));
    endtask

    task automatic finish_block();
        @(negedge clk);
        check("R8 done high", 64'(done), 64'd1);
        @(negedge clk);
        check("R8 done one cycle", 64'(done), 64'd0);
        check("R6 idle after block", 64'(row_ready), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 out_valid reset", 64'(out_valid), 64'd0);
        check("R10 done reset", 64'(done), 64'd0);
        check("R10 row_ready reset", 64'(row_ready), 64'd0);
        rst_n = 1'b1;

        // table walk: R1 R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            begin_block(DC_TAB[i]);
            for (int r = 0; r < 4; r++) begin
                send_row(rot(PRED_TAB[i], r), rot(CUR_TAB[i], r), ref_res(DC_TAB[i]), "R1/R2/R3/R4/R5 row");
            end
            finish_block();
        end

        // R4 explicit: dc -640 gives residual -10, pred 5 clips to 0
        begin_block(16'hFD80);
        send_row(64'h0009_000A_0005_0000, 64'hFFFF_FFFF_FFFF_FFFF, -10, "R4 clip low");
        check("R4 byte0 zero", 64'(out_row[7:0]), 64'd0);
        // R5 explicit: residual stays -10 so 0xFF gives 0xF5 (no wrap)
        send_row(64'h00FF_00FF_00FF_00FF, 64'h0, -10, "R5 row");
        send_row(64'h0, 64'h0, -10, "R4 row3");
        send_row(64'h0, 64'h0, -10, "R4 row4");
        finish_block();

        // R6: row_valid while idle is ignored
        row_valid = 1'b1;
        pred_row  = 64'h1111_1111_1111_1111;
        @(negedge clk);
        @(negedge clk);
        check("R6 idle ready low", 64'(row_ready), 64'd0);
        check("R6 idle no output", 64'(out_valid), 64'd0);
        row_valid = 1'b0;

        // R7 backpressure and R9 ignored start, dc 640 gives residual 10
        begin_block(16'd640);
        out_ready = 1'b0;
        row_valid = 1'b1;
        pred_row  = 64'h00F8_0010_0020_0030;
        cur_row   = 64'hAB00_CD00_EF00_1200;
        @(negedge clk);
        check("R7 out_valid", 64'(out_valid), 64'd1);
        check("R7 first row", out_row, ref_row(64'h00F8_0010_0020_0030, 64'hAB00_CD00_EF00_1200, 10));
        pred_row  = 64'h0040_0050_0060_00FA;
        cur_row   = 64'h9900_8800_7700_6600;
        check("R7 ready low when full", 64'(row_ready), 64'd0);
        start = 1'b1;
        dc_in = 16'h8000;
        @(negedge clk);
        start = 1'b0;
        check("R7 held row", out_row, ref_row(64'h00F8_0010_0020_0030, 64'hAB00_CD00_EF00_1200, 10));
        check("R7 still valid", 64'(out_valid), 64'd1);
        out_ready = 1'b1;
        @(negedge clk);
        row_valid = 1'b0;
        check("R9 second row old residual", out_row, ref_row(64'h0040_0050_0060_00FA, 64'h9900_8800_7700_6600, 10));
        send_row(64'h0001_0002_0003_0004, 64'h5500_5500_5500_5500, 10, "R9 row3");
        send_row(64'h00F5_00F6_00F7_00F4, 64'h0, 10, "R5/R9 row4");
        finish_block();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule